// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the register-facing half of an SMBus host. Software programs a slave address, a command byte, one or two data bytes and a protocol code, then sets a start bit. The block breaks the transaction into byte-level requests (start plus address, write byte, read byte, stop) for a separate bit-level bus engine. It also reports the outcome through write-one-to-clear status flags and an interrupt line.

Block transfers move one byte at a time. After each payload byte the sequencer raises a byte-done flag and stops issuing requests until software clears it. Software supplies the next outgoing byte, or collects the received one, through a single block-byte register. Software marks the final read byte with a last-byte control bit so the engine NACKs it. A kill bit aborts any transaction in flight.

Register offsets: 0 status, 1 control, 2 command, 3 slave address, 4 data low, 5 data high, 6 block byte. Reading offset 7 returns zero.

Top module: `smbus_host_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. Status bits are: 7 byte done, 6 in use, 5 alert, 4 failed, 3 bus error, 2 device error, 1 complete, 0 busy. The in-use bit is set by a status read.
- R2: Writing a one to a status bit in 7..1 clears that bit. Writing zero leaves it unchanged. A set event in the same cycle wins over the clear. Software cannot write the busy bit.
- R3: Writing control with bit 6 (start) set, while busy is clear and the kill bit is not written, raises busy on the next cycle. A start written while busy is set is ignored. Bus requests occur only while busy is set.
- R4: Control bits [4:2] select the protocol: 000 quick, 001 byte, 010 byte-data, 011 word-data, 101 block, 110 raw I2C block read. The request opcodes are 0 start+address, 1 write, 2 read, 3 stop. Address bits [7:1] hold the slave and bit 0 the read flag. The first address phase carries the read flag only for quick and byte. Protocols with a command byte send it next, and reads then issue a repeated start with bit 0 set. Byte-data writes send the data low byte.
- R5: A word read stores the first received byte in data low and the second in data high. Only the second is NACKed. A word write sends data low, then data high.
- R6: Protocol codes 100 and 111 set device error at once, with no bus request.
- R7: A NAK on any request other than stop ends the transaction with a stop, then sets device error instead of complete.
- R8: Lost arbitration sets bus error and ends the transaction with no stop.
- R9: In block mode, byte done is set after each payload byte. No bus request is issued until software clears it.
- R10: A block-mode read is NACKed when the last-byte control bit is set. A raw I2C block read finishes after the byte read with last-byte set.
- R11: In a block read, the first received byte is the count and is stored in data low. A count of 0 or above 32 ends the transaction with device error. A block write whose data-low count is 0 or above 32 fails the same way, with no bus request.
- R12: Setting the kill bit during a transaction clears busy, sets failed and withdraws any pending request.
- R13: `irq` = control bit 0 AND (complete OR device error OR bus error OR failed OR byte done).
- R14: A normal transaction ends with a stop request. Complete is set in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (sets in-use on status reads) |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| alertIn | input | 1 | Bus alert level, latched into the alert flag |
| irq | output | 1 | Interrupt request |
| engReq | output | 1 | Request to the bus engine, held until `engDone` |
| engOp | output | 2 | Request opcode |
| engTxByte | output | 8 | Byte to send for start and write requests |
| engNack | output | 1 | NACK the byte of a read request |
| engDone | input | 1 | One-cycle completion of the current request |
| engNak | input | 1 | With `engDone`: the slave did not acknowledge |
| engArbLost | input | 1 | With `engDone`: arbitration was lost |
| engRxByte | input | 8 | With `engDone`: byte received by a read |

## Verification
The embedded properties check, on every cycle, that requests appear only while busy and stop while byte done is stalling the sequencer. They also check that busy never falls without a completion or error flag, that a held kill keeps busy low, and that lost arbitration withdraws the request. The directed scenarios are the only evidence for the exact order of request bytes in each protocol and for the data-low/data-high placement. The same holds for last-byte NACK marking, count capture and its limits, unsupported codes, and the interrupt gating.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} busOp_e;

  localparam logic [2:0] P_QUICK = 3'd0;
  localparam logic [2:0] P_BYTE  = 3'd1;
  localparam logic [2:0] P_BDATA = 3'd2;
  localparam logic [2:0] P_WORD  = 3'd3;
  localparam logic [2:0] P_PCALL = 3'd4;
  localparam logic [2:0] P_BLOCK = 3'd5;
  localparam logic [2:0] P_I2CRD = 3'd6;
  localparam logic [2:0] P_RSVD  = 3'd7;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_ADDR = 3'd3;
  localparam logic [2:0] A_DAT0 = 3'd4;
  localparam logic [2:0] A_DAT1 = 3'd5;
  localparam logic [2:0] A_BLK  = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_RSTART, S_WR0, S_WR1, S_RD0, S_RD1,
    S_CNTW, S_BLKW, S_WAITW, S_RDCNT, S_BLKR, S_WAITR, S_STOP
  } seqState_e;

  typedef struct packed {
    logic       finOk;
    logic       finDev;
    logic       finBus;
    logic       finFail;
    logic       setByteDone;
    logic       ldData0;
    logic       ldData1;
    logic       ldBlk;
    logic [7:0] rxByte;
  } seqStrobe_t;
endpackage

// File: rtl/smbh_regs.sv
module smbh_regs
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       alertIn,
  input  seqStrobe_t strb,
  output logic       goQ,
  output logic       busy,
  output logic       kill,
  output logic       lastByte,
  output logic [2:0] proto,
  output logic [7:0] addrReg,
  output logic [7:0] cmdReg,
  output logic [7:0] data0,
  output logic [7:0] data1,
  output logic [7:0] blkByte,
  output logic       byteDone,
  output logic       irq
);
  logic intrEn, pecEn, inUse, alert, failed, busErr, devErr, intr;
  logic wrStat, wrCtl, startOk, finAny;
  logic [7:0] clr;

  assign wrStat  = regWe && (regAddr == A_STAT);
  assign wrCtl   = regWe && (regAddr == A_CTRL);
  assign clr     = wrStat ? regWdata : 8'h00;
  assign startOk = wrCtl && regWdata[6] && !regWdata[1] && !busy;
  assign finAny  = strb.finOk | strb.finDev | strb.finBus | strb.finFail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goQ <= 1'b0; busy <= 1'b0;
      intrEn <= 1'b0; kill <= 1'b0; lastByte <= 1'b0; proto <= 3'd0; pecEn <= 1'b0;
      inUse <= 1'b0; alert <= 1'b0; failed <= 1'b0; busErr <= 1'b0;
      devErr <= 1'b0; intr <= 1'b0; byteDone <= 1'b0;
      addrReg <= 8'h00; cmdReg <= 8'h00; data0 <= 8'h00; data1 <= 8'h00; blkByte <= 8'h00;
    end else begin
      goQ <= startOk;
      if (startOk) busy <= 1'b1;
      else if (finAny) busy <= 1'b0;
      byteDone <= strb.setByteDone | (byteDone & ~clr[7]);
      inUse    <= (regRe && regAddr == A_STAT) | (inUse & ~clr[6]);
      alert    <= alertIn | (alert & ~clr[5]);
      failed   <= strb.finFail | (failed & ~clr[4]);
      busErr   <= strb.finBus | (busErr & ~clr[3]);
      devErr   <= strb.finDev | (devErr & ~clr[2]);
      intr     <= strb.finOk | (intr & ~clr[1]);
      if (wrCtl) begin
        intrEn   <= regWdata[0];
        kill     <= regWdata[1];
        lastByte <= regWdata[5];
        if (!busy) begin
          proto <= regWdata[4:2];
          pecEn <= regWdata[7];
        end
      end
      if (regWe && regAddr == A_CMD)  cmdReg  <= regWdata;
      if (regWe && regAddr == A_ADDR) addrReg <= regWdata;
      if (strb.ldData0) data0 <= strb.rxByte;
      else if (regWe && regAddr == A_DAT0) data0 <= regWdata;
      if (strb.ldData1) data1 <= strb.rxByte;
      else if (regWe && regAddr == A_DAT1) data1 <= regWdata;
      if (strb.ldBlk) blkByte <= strb.rxByte;
      else if (regWe && regAddr == A_BLK) blkByte <= regWdata;
    end
  end

  always_comb begin
    case (regAddr)
      A_STAT:  regRdata = {byteDone, inUse, alert, failed, busErr, devErr, intr, busy};
      A_CTRL:  regRdata = {pecEn, 1'b0, lastByte, proto, kill, intrEn};
      A_CMD:   regRdata = cmdReg;
      A_ADDR:  regRdata = addrReg;
      A_DAT0:  regRdata = data0;
      A_DAT1:  regRdata = data1;
      A_BLK:   regRdata = blkByte;
      default: regRdata = 8'h00;
    endcase
  end

  assign irq = intrEn & (intr | devErr | busErr | failed | byteDone);

  // R14: busy only falls alongside an outcome flag
  a_r14_fall_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (intr || devErr || busErr || failed));
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
#(
  parameter int BLOCK_MAX = 32
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goQ,
  input  logic       kill,
  input  logic       lastByte,
  input  logic [2:0] proto,
  input  logic [7:0] addrReg,
  input  logic [7:0] cmdReg,
  input  logic [7:0] data0,
  input  logic [7:0] data1,
  input  logic [7:0] blkByte,
  input  logic       byteDone,
  input  logic       engDone,
  input  logic       engNak,
  input  logic       engArbLost,
  input  logic [7:0] engRxByte,
  output logic       engReq,
  output busOp_e     engOp,
  output logic [7:0] engTxByte,
  output logic       engNack,
  output seqStrobe_t strb
);
  localparam int CW = $clog2(BLOCK_MAX + 1);

  seqState_e st, nxt;
  logic          errSeen, errNxt, lastRd, lastNxt;
  logic [CW-1:0] cnt, cntNxt, idx, idxNxt;
  logic          rw, firstBit, badW, badR;

  assign rw       = addrReg[0];
  assign firstBit = (proto == P_QUICK || proto == P_BYTE) ? rw : 1'b0;
  assign badW     = (data0 == 8'h00) || (int'(data0) > BLOCK_MAX);
  assign badR     = (engRxByte == 8'h00) || (int'(engRxByte) > BLOCK_MAX);

  always_comb begin
    nxt = st; errNxt = errSeen; lastNxt = lastRd; cntNxt = cnt; idxNxt = idx;
    strb = '0; strb.rxByte = engRxByte;
    engReq = 1'b0; engOp = OP_STOP; engTxByte = 8'h00; engNack = 1'b0;
    case (st)
      S_ADDR:   begin engReq = 1'b1; engOp = OP_START; engTxByte = {addrReg[7:1], firstBit}; end
      S_RSTART: begin engReq = 1'b1; engOp = OP_START; engTxByte = {addrReg[7:1], 1'b1}; end
      S_CMD:    begin engReq = 1'b1; engOp = OP_WRITE; engTxByte = cmdReg; end
      S_WR0, S_CNTW: begin engReq = 1'b1; engOp = OP_WRITE; engTxByte = data0; end
      S_WR1:    begin engReq = 1'b1; engOp = OP_WRITE; engTxByte = data1; end
      S_BLKW:   begin engReq = 1'b1; engOp = OP_WRITE; engTxByte = blkByte; end
      S_RD0:    begin engReq = 1'b1; engOp = OP_READ; engNack = (proto != P_WORD); end
      S_RD1:    begin engReq = 1'b1; engOp = OP_READ; engNack = 1'b1; end
      S_RDCNT:  begin engReq = 1'b1; engOp = OP_READ; end
      S_BLKR:   begin engReq = 1'b1; engOp = OP_READ; engNack = lastByte; end
      S_STOP:   begin engReq = 1'b1; engOp = OP_STOP; end
      default:  ;
    endcase

    if (st != S_IDLE && kill) begin
      engReq = 1'b0; strb.finFail = 1'b1; nxt = S_IDLE;
    end else if (st == S_IDLE) begin
      if (goQ) begin
        if (kill) strb.finFail = 1'b1;
        else if (proto == P_PCALL || proto == P_RSVD || (proto == P_BLOCK && !rw && badW))
          strb.finDev = 1'b1;
        else begin nxt = S_ADDR; errNxt = 1'b0; end
      end
    end else if (st == S_WAITW) begin
      if (!byteDone) nxt = (idx == cnt) ? S_STOP : S_BLKW;
    end else if (st == S_WAITR) begin
      if (!byteDone) nxt = ((proto == P_BLOCK) ? (idx == cnt) : lastRd) ? S_STOP : S_BLKR;
    end else if (engDone) begin
      if (engArbLost) begin
        strb.finBus = 1'b1; nxt = S_IDLE;
      end else if (engNak && st != S_STOP) begin
        errNxt = 1'b1; nxt = S_STOP;
      end else begin
        case (st)
          S_ADDR:   nxt = (proto == P_QUICK) ? S_STOP : (proto == P_BYTE && rw) ? S_RD0 : S_CMD;
          S_CMD: begin
            if (proto == P_BYTE) nxt = S_STOP;
            else if (proto == P_I2CRD || rw) nxt = S_RSTART;
            else if (proto == P_BLOCK) nxt = S_CNTW;
            else nxt = S_WR0;
          end
          S_RSTART: nxt = (proto == P_BLOCK) ? S_RDCNT : (proto == P_I2CRD) ? S_BLKR : S_RD0;
          S_WR0:    nxt = (proto == P_WORD) ? S_WR1 : S_STOP;
          S_WR1:    nxt = S_STOP;
          S_RD0: begin strb.ldData0 = 1'b1; nxt = (proto == P_WORD) ? S_RD1 : S_STOP; end
          S_RD1: begin strb.ldData1 = 1'b1; nxt = S_STOP; end
          S_CNTW: begin cntNxt = data0[CW-1:0]; idxNxt = '0; nxt = S_BLKW; end
          S_BLKW: begin strb.setByteDone = 1'b1; idxNxt = idx + 1'b1; nxt = S_WAITW; end
          S_RDCNT: begin
            strb.ldData0 = 1'b1;
            if (badR) begin errNxt = 1'b1; nxt = S_STOP; end
            else begin cntNxt = engRxByte[CW-1:0]; idxNxt = '0; nxt = S_BLKR; end
          end
          S_BLKR: begin
            strb.ldBlk = 1'b1; strb.setByteDone = 1'b1;
            idxNxt = idx + 1'b1; lastNxt = lastByte; nxt = S_WAITR;
          end
          S_STOP: begin
            if (errSeen) strb.finDev = 1'b1; else strb.finOk = 1'b1;
            nxt = S_IDLE;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_IDLE; errSeen <= 1'b0; lastRd <= 1'b0; cnt <= '0; idx <= '0;
    end else begin
      st <= nxt; errSeen <= errNxt; lastRd <= lastNxt; cnt <= cntNxt; idx <= idxNxt;
    end
  end

  // R8: a lost bus is released, never retried
  a_r8_arb_release: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && engDone && engArbLost) |=> !engReq);
endmodule

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbh_pkg::*;
#(
  parameter int BLOCK_MAX = 32
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       alertIn,
  output logic       irq,
  output logic       engReq,
  output logic [1:0] engOp,
  output logic [7:0] engTxByte,
  output logic       engNack,
  input  logic       engDone,
  input  logic       engNak,
  input  logic       engArbLost,
  input  logic [7:0] engRxByte
);
  seqStrobe_t strb;
  busOp_e     opE;
  logic       goQ, busy, kill, lastByte, byteDone;
  logic [2:0] proto;
  logic [7:0] addrReg, cmdReg, data0, data1, blkByte;

  smbh_regs uRegs (
    .clk, .rstN, .regWe, .regRe, .regAddr, .regWdata, .regRdata, .alertIn,
    .strb, .goQ, .busy, .kill, .lastByte, .proto, .addrReg, .cmdReg,
    .data0, .data1, .blkByte, .byteDone, .irq
  );

  smbh_seq #(.BLOCK_MAX(BLOCK_MAX)) uSeq (
    .clk, .rstN, .goQ, .kill, .lastByte, .proto, .addrReg, .cmdReg,
    .data0, .data1, .blkByte, .byteDone, .engDone, .engNak, .engArbLost,
    .engRxByte, .engReq, .engOp(opE), .engTxByte, .engNack, .strb
  );

  assign engOp = opE;

  // R3: the engine is only ever asked for work during a busy transaction
  a_r3_req_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    engReq |-> busy);
  // R9: once byte done rises the sequencer holds off the engine
  a_r9_stall_no_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteDone) |-> !engReq);
  // R12: a kill held for two cycles leaves nothing busy
  a_r12_kill_idle: assert property (@(posedge clk) disable iff (!rstN)
    (kill && $past(kill)) |-> !busy);
endmodule

// File: tb/sim_smbus_host_ctrl.sv
module sim_smbus_host_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0, alertIn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'h00, regRdata;
  logic irq, engReq, engNack;
  logic [1:0] engOp;
  logic [7:0] engTxByte;
  logic engDone = 1'b0, engNak = 1'b0, engArbLost = 1'b0;
  logic [7:0] engRxByte = 8'h00;

  smbus_host_ctrl u0 (.*);

  always #4 clk = ~clk;

  int nChk = 0, nFail = 0;
  int logN = 0, rxPtr = 0, nakAt = -1, arbAt = -1, wcnt = 0;
  logic [1:0] logOp [0:63];
  logic [7:0] logTx [0:63];
  logic       logNk [0:63];
  logic [7:0] rxQ   [0:15];

  // bus engine model: answers each request two cycles after it appears
  always @(negedge clk) begin
    if (engDone) begin
      engDone = 1'b0; engNak = 1'b0; engArbLost = 1'b0;
    end else if (engReq) begin
      if (wcnt == 1) begin
        logOp[logN] = engOp; logTx[logN] = engTxByte; logNk[logN] = engNack;
        if (engOp == 2'd2) begin engRxByte = rxQ[rxPtr]; rxPtr++; end
        engNak = (logN == nakAt); engArbLost = (logN == arbAt);
        logN++; engDone = 1'b1; wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    regAddr = a; #1 d = regRdata;
  endtask

  task automatic waitBit(int b, logic v, string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); peek(3'd0, s);
      if (s[b] == v) return;
    end
    check({tag, " timeout"}, 0, 1);
  endtask

  task automatic chkLog(int i, int op, int tx, string tag);
    check({tag, " op"}, logOp[i], op);
    if (op < 2) check({tag, " byte"}, logTx[i], tx);
  endtask

  task automatic prep();
    regWr(3'd0, 8'hFE);
    logN = 0; rxPtr = 0; nakAt = -1; arbAt = -1;
  endtask

  task automatic tReset();
    logic [7:0] d;
    peek(3'd0, d); check("R1 status after reset", d, 8'h00);
    peek(3'd1, d); check("R1 control after reset", d, 8'h00);
    check("R1 irq after reset", irq, 0);
    @(negedge clk); regRe = 1'b1; regAddr = 3'd0; @(negedge clk); regRe = 1'b0;
    peek(3'd0, d); check("R1 in-use after status read", d[6], 1);
  endtask

  task automatic tQuick();
    logic [7:0] d;
    prep();
    regWr(3'd3, 8'hA0); regWr(3'd1, 8'h40);
    peek(3'd0, d); check("R3 busy next cycle", d[0], 1);
    waitBit(0, 1'b0, "R14 quick");
    check("R14 quick length", logN, 2);
    chkLog(0, 0, 8'hA0, "R4 quick addr"); chkLog(1, 3, 0, "R14 quick stop");
    peek(3'd0, d); check("R14 complete flag", d & 8'hBF, 8'h02);
    check("R13 irq masked", irq, 0);
    regWr(3'd1, 8'h01); check("R13 irq enabled", irq, 1);
    regWr(3'd0, 8'h00); peek(3'd0, d); check("R2 zero write keeps", d[1], 1);
    regWr(3'd0, 8'h02); peek(3'd0, d); check("R2 one write clears", d[1], 0);
    check("R13 irq after clear", irq, 0);
  endtask

  task automatic tByteDataWr();
    prep();
    regWr(3'd3, 8'hA0); regWr(3'd2, 8'h12); regWr(3'd4, 8'h34);
    regWr(3'd1, 8'h48); regWr(3'd1, 8'h48);
    waitBit(0, 1'b0, "R4 bdata");
    check("R3 second start ignored", logN, 4);
    chkLog(0, 0, 8'hA0, "R4 bdata addr"); chkLog(1, 1, 8'h12, "R4 bdata cmd");
    chkLog(2, 1, 8'h34, "R4 bdata data"); chkLog(3, 3, 0, "R4 bdata stop");
  endtask

  task automatic tWord();
    logic [7:0] d;
    prep();
    rxQ[0] = 8'hCD; rxQ[1] = 8'hAB;
    regWr(3'd3, 8'hA1); regWr(3'd2, 8'h07); regWr(3'd1, 8'h4C);
    waitBit(0, 1'b0, "R5 word rd");
    check("R5 word rd length", logN, 6);
    chkLog(0, 0, 8'hA0, "R4 word first addr"); chkLog(1, 1, 8'h07, "R4 word cmd");
    chkLog(2, 0, 8'hA1, "R4 word restart");
    check("R5 low ack", logNk[3], 0); check("R5 high nack", logNk[4], 1);
    peek(3'd4, d); check("R5 data low", d, 8'hCD);
    peek(3'd5, d); check("R5 data high", d, 8'hAB);
    prep();
    regWr(3'd3, 8'hA0); regWr(3'd4, 8'h11); regWr(3'd5, 8'h22); regWr(3'd1, 8'h4C);
    waitBit(0, 1'b0, "R5 word wr");
    chkLog(2, 1, 8'h11, "R5 write low"); chkLog(3, 1, 8'h22, "R5 write high");
  endtask

  task automatic tErrors();
    logic [7:0] d;
    prep(); nakAt = 0;
    regWr(3'd3, 8'hA0); regWr(3'd1, 8'h40);
    waitBit(0, 1'b0, "R7 nak");
    check("R7 stop after nak", logN, 2); chkLog(1, 3, 0, "R7 stop");
    peek(3'd0, d); check("R7 device error only", d & 8'hBF, 8'h04);
    prep(); arbAt = 1;
    regWr(3'd3, 8'hA0); regWr(3'd1, 8'h48);
    waitBit(0, 1'b0, "R8 arb");
    check("R8 no stop", logN, 2);
    peek(3'd0, d); check("R8 bus error", d & 8'hBF, 8'h08);
    prep();
    regWr(3'd1, 8'h50);
    repeat (4) @(negedge clk);
    check("R6 no request", logN, 0);
    peek(3'd0, d); check("R6 device error", d & 8'hBF, 8'h04);
  endtask

  task automatic tBlockWr();
    logic [7:0] d;
    prep();
    regWr(3'd3, 8'hA0); regWr(3'd2, 8'h20); regWr(3'd4, 8'h02); regWr(3'd6, 8'h11);
    regWr(3'd1, 8'h54);
    waitBit(7, 1'b1, "R9 first byte");
    repeat (20) @(negedge clk);
    check("R9 stalled count", logN, 4);
    check("R9 no request while stalled", engReq, 0);
    chkLog(2, 1, 8'h02, "R9 count byte"); chkLog(3, 1, 8'h11, "R9 first data");
    regWr(3'd6, 8'h22); regWr(3'd0, 8'h80);
    waitBit(7, 1'b1, "R9 second byte");
    chkLog(4, 1, 8'h22, "R9 second data");
    regWr(3'd0, 8'h80);
    waitBit(0, 1'b0, "R9 block end");
    chkLog(5, 3, 0, "R9 stop"); check("R9 length", logN, 6);
    prep(); regWr(3'd4, 8'h00); regWr(3'd1, 8'h54);
    repeat (4) @(negedge clk);
    peek(3'd0, d); check("R11 bad write count", d & 8'hBF, 8'h04);
    check("R11 no request", logN, 0);
  endtask

  task automatic tBlockRd();
    logic [7:0] d;
    prep();
    rxQ[0] = 8'd2; rxQ[1] = 8'h5A; rxQ[2] = 8'h6B;
    regWr(3'd3, 8'hA1); regWr(3'd2, 8'h30); regWr(3'd1, 8'h54);
    waitBit(7, 1'b1, "R11 first");
    peek(3'd4, d); check("R11 count in data low", d, 8'd2);
    peek(3'd6, d); check("R10 first byte", d, 8'h5A);
    regWr(3'd1, 8'h34); regWr(3'd0, 8'h80);
    waitBit(7, 1'b1, "R10 second");
    peek(3'd6, d); check("R10 last byte", d, 8'h6B);
    regWr(3'd0, 8'h80);
    waitBit(0, 1'b0, "R10 end");
    check("R10 length", logN, 7);
    check("R10 count ack", logNk[3], 0); check("R10 mid ack", logNk[4], 0);
    check("R10 last nack", logNk[5], 1); chkLog(6, 3, 0, "R10 stop");
    for (int k = 0; k < 2; k++) begin
      prep(); rxQ[0] = (k == 0) ? 8'd0 : 8'd33;
      regWr(3'd1, 8'h54);
      waitBit(0, 1'b0, "R11 bad count");
      peek(3'd0, d); check("R11 bad read count", d & 8'hBF, 8'h04);
      check("R11 stop after count", logN, 5);
    end
    prep(); rxQ[0] = 8'h01; rxQ[1] = 8'h02;
    regWr(3'd1, 8'h58);
    waitBit(7, 1'b1, "R10 i2c first");
    regWr(3'd1, 8'h38); regWr(3'd0, 8'h80);
    waitBit(7, 1'b1, "R10 i2c second");
    regWr(3'd0, 8'h80);
    waitBit(0, 1'b0, "R10 i2c end");
    check("R10 i2c length", logN, 6);
    check("R10 i2c last nack", logNk[4], 1); chkLog(5, 3, 0, "R10 i2c stop");
  endtask

  task automatic tKill();
    logic [7:0] d;
    prep();
    regWr(3'd3, 8'hA0); regWr(3'd4, 8'h03); regWr(3'd1, 8'h54);
    waitBit(7, 1'b1, "R12 stall");
    regWr(3'd1, 8'h02);
    repeat (3) @(negedge clk);
    peek(3'd0, d); check("R12 failed and idle", d & 8'hBF, 8'h90);
    check("R12 request withdrawn", engReq, 0);
    regWr(3'd1, 8'h00); regWr(3'd0, 8'hFE);
  endtask

  initial begin
    #(8 * 200000);
    nFail++; nChk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tQuick();
    tByteDataWr();
    tWord();
    tErrors();
    tBlockWr();
    tBlockRd();
    tKill();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule